// File: doc/BRIEF.md
# Key-Protected Acknowledgment Timeout Watchdog

This block guards the startup of a processor. As soon as reset is released, a counter begins to climb by one step per prescaled tick. Software must prove it is alive by writing a fixed pair of 32-bit keys to an acknowledgment register before that counter reaches a programmable deadline. If the deadline is reached first, a sticky timeout alarm is raised toward an external alarm controller.

The deadline sits in a timeout register that is write-protected. It can only be changed after a 7-bit unlock code has been written into the top byte of that register. Writing zero to the top byte locks it again. A deadline of zero switches the watchdog off. Any wrong key, whether for the lock or for the acknowledgment, raises a second sticky alarm. The timeout register is always visible on a read port, with the deadline, the live counter and the unlock status in fixed byte positions.

Top module: `ack_timeout_wdog`

## Requirements
- R1: After reset, `timeout_rdata` reads deadline 0xFF in bits [7:0], counter 0 in bits [15:8], unlock status 0 in bit 24, and zero in all other bits. Both alarms are low.
- R2: While running, the counter rises by exactly one every TICK_CYCLES clocks. It starts when reset is released and never changes by any other step.
- R3: A full-word write of 0x78A5C3E1 to the acknowledgment register (`reg_sel`=1), followed by the next acknowledgment write of 0x875A3C1E, acknowledges the watchdog. The counter then freezes for good, and later acknowledgment writes have no effect.
- R4: A write to the timeout register (`reg_sel`=0) with lane 3 enabled and bits [31:25] equal to 0x19 unlocks it, and bit 24 then reads 1. Bit 24 of the written value is ignored. A lane-3 write of 0x00 locks the register again.
- R5: A lane-0 write to the timeout register changes the deadline only if the register was already unlocked before that write. While locked, the deadline keeps its value.
- R6: If the counter reaches the nonzero deadline without an acknowledgment, `alarm_timeout` rises and stays high until reset. The counter halts at the deadline.
- R7: A lane-3 write whose byte is neither 0x00 nor an unlock code raises `alarm_key` and leaves the register locked. `alarm_key` stays high until reset.
- R8: An acknowledgment write that breaks the sequence raises `alarm_key` and restarts the sequence from the first key. This covers a first write other than 0x78A5C3E1, a second write other than 0x875A3C1E, and any write without all four byte lanes. The counter keeps running.
- R9: A deadline of 0 freezes the counter and never raises `alarm_timeout`.
- R10: Lowering the deadline to a value at or below the current count raises `alarm_timeout` on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the timeout register, 1 selects the acknowledgment register |
| wr_be | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data |
| timeout_rdata | output | 32 | Live view of the timeout register |
| alarm_timeout | output | 1 | Sticky alarm: deadline reached without acknowledgment |
| alarm_key | output | 1 | Sticky alarm: wrong lock or acknowledgment key |

## Verification
The hardest situation to reach is a deadline that has been lowered beneath a counter that is already running. This needs the counter to be well advanced, then an unlock, then a lane-0 write, all before any tick can carry the count past the old value. The bench builds the block with a four-cycle tick so that the count can be advanced quickly. It waits a fixed number of cycles, reads the count back through `timeout_rdata`, and then unlocks the register and writes a smaller deadline. It then checks that the alarm rises on the very next clock and that the count stays frozen.

// File: rtl/ack_wdog_pkg.sv
package ack_wdog_pkg;
  localparam int unsigned FIELD_W   = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LANES     = DATA_W / 8;
  localparam int unsigned DL_LANE   = 0;
  localparam int unsigned CNT_LANE  = 1;
  localparam int unsigned LOCK_LANE = 3;
  localparam int unsigned UL_BIT    = LOCK_LANE * 8;

  localparam logic SEL_TIMEOUT = 1'b0;
  localparam logic SEL_ACK     = 1'b1;

  typedef enum logic [0:0] {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_state_e;
endpackage

// File: rtl/ack_wdog_prescaler.sv
module ack_wdog_prescaler #(
  parameter int unsigned TICK_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (TICK_CYCLES <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int unsigned PRE_W = $clog2(TICK_CYCLES);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;

      assign tick   = run && (pre_q == PRE_LAST);
      assign pre_en = run;

      always_comb begin
        if (tick) pre_d = '0;
        else      pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (pre_en) pre_q <= pre_d;
      end
    end
  endgenerate
endmodule

// File: rtl/ack_wdog_counter.sv
module ack_wdog_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             acked,
  input  logic [CNT_W-1:0] deadline,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             exp_q, exp_d, exp_en;
  logic             armed, reached;

  assign armed   = !acked && (deadline != '0);
  assign reached = (cnt_q >= deadline);
  assign run     = armed && !reached;

  always_comb begin
    cnt_en = tick;
    cnt_d  = cnt_q + 1'b1;
  end

  always_comb begin
    exp_en = armed && reached && !exp_q;
    exp_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exp_q <= 1'b0;
    else if (exp_en) exp_q <= exp_d;
  end

  assign cnt     = cnt_q;
  assign expired = exp_q;
endmodule

// File: rtl/ack_wdog_keyseq.sv
module ack_wdog_keyseq
  import ack_wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_A = 32'h78A5C3E1,
  parameter logic [DATA_W-1:0] KEY_B = 32'h875A3C1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic              acked,
  output logic              key_err
);
  key_state_e st_q, st_d;
  logic       st_en;
  logic       ack_q, ack_d, ack_en;
  logic       full_word;

  assign full_word = &wr_be;

  always_comb begin
    st_d    = st_q;
    ack_d   = ack_q;
    key_err = 1'b0;
    if (wr_stb && !ack_q) begin
      unique case (st_q)
        KEY_IDLE: begin
          if (full_word && wr_data == KEY_A) begin
            st_d = KEY_HALF;
          end else begin
            key_err = 1'b1;
          end
        end
        KEY_HALF: begin
          st_d = KEY_IDLE;
          if (full_word && wr_data == KEY_B) begin
            ack_d = 1'b1;
          end else begin
            key_err = 1'b1;
          end
        end
        default: st_d = KEY_IDLE;
      endcase
    end
  end

  assign st_en  = wr_stb && !ack_q;
  assign ack_en = wr_stb && !ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= KEY_IDLE;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_q <= 1'b0;
    else if (ack_en) ack_q <= ack_d;
  end

  assign acked = ack_q;
endmodule

// File: rtl/ack_wdog_lockreg.sv
module ack_wdog_lockreg
  import ack_wdog_pkg::*;
#(
  parameter logic [FIELD_W-1:0] DL_RST     = 8'hFF,
  parameter logic [6:0]         UNLOCK_KEY = 7'h19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic               be_dl,
  input  logic               be_lock,
  input  logic [FIELD_W-1:0] dl_byte,
  input  logic [7:0]         lock_byte,
  output logic [FIELD_W-1:0] deadline,
  output logic               unlocked,
  output logic               key_err
);
  logic [FIELD_W-1:0] dl_q, dl_d;
  logic               dl_en;
  logic               ul_q, ul_d, ul_en;

  always_comb begin
    dl_en = wr_stb && be_dl && ul_q;
    dl_d  = dl_byte;
  end

  always_comb begin
    ul_en   = wr_stb && be_lock;
    ul_d    = 1'b0;
    key_err = 1'b0;
    if (lock_byte == 8'h00) begin
      ul_d = 1'b0;
    end else if (lock_byte[7:1] == UNLOCK_KEY) begin
      ul_d = 1'b1;
    end else begin
      ul_d    = 1'b0;
      key_err = ul_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dl_q <= DL_RST;
    else if (dl_en) dl_q <= dl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ul_q <= 1'b0;
    else if (ul_en) ul_q <= ul_d;
  end

  assign deadline = dl_q;
  assign unlocked = ul_q;
endmodule

// File: rtl/ack_timeout_wdog.sv
module ack_timeout_wdog
  import ack_wdog_pkg::*;
#(
  parameter int unsigned         TICK_CYCLES = 4096,
  parameter logic [FIELD_W-1:0]  DL_RST      = 8'hFF,
  parameter logic [6:0]          UNLOCK_KEY  = 7'h19,
  parameter logic [DATA_W-1:0]   ACK_KEY_A   = 32'h78A5C3E1,
  parameter logic [DATA_W-1:0]   ACK_KEY_B   = 32'h875A3C1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] timeout_rdata,
  output logic              alarm_timeout,
  output logic              alarm_key
);
  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic               to_stb, ack_stb;
  logic               tick, run, acked_q;
  logic [FIELD_W-1:0] cnt_q, deadline_q;
  logic               unlocked_q;
  logic               lock_err, seq_err;
  logic               akey_q, akey_d, akey_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign to_stb  = wr_en && (reg_sel == SEL_TIMEOUT);
  assign ack_stb = wr_en && (reg_sel == SEL_ACK);

  ack_wdog_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tick)
  );

  ack_wdog_counter #(.CNT_W(FIELD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .acked    (acked_q),
    .deadline (deadline_q),
    .cnt      (cnt_q),
    .run      (run),
    .expired  (alarm_timeout)
  );

  ack_wdog_keyseq #(.KEY_A(ACK_KEY_A), .KEY_B(ACK_KEY_B)) u_key (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_stb  (ack_stb),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .acked   (acked_q),
    .key_err (seq_err)
  );

  ack_wdog_lockreg #(.DL_RST(DL_RST), .UNLOCK_KEY(UNLOCK_KEY)) u_lock (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_stb    (to_stb),
    .be_dl     (wr_be[DL_LANE]),
    .be_lock   (wr_be[LOCK_LANE]),
    .dl_byte   (wr_data[DL_LANE*8 +: FIELD_W]),
    .lock_byte (wr_data[LOCK_LANE*8 +: 8]),
    .deadline  (deadline_q),
    .unlocked  (unlocked_q),
    .key_err   (lock_err)
  );

  always_comb begin
    akey_en = (lock_err || seq_err) && !akey_q;
    akey_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  akey_q <= 1'b0;
    else if (akey_en) akey_q <= akey_d;
  end
  assign alarm_key = akey_q;

  always_comb begin
    timeout_rdata                          = '0;
    timeout_rdata[DL_LANE*8 +: FIELD_W]    = deadline_q;
    timeout_rdata[CNT_LANE*8 +: FIELD_W]   = cnt_q;
    timeout_rdata[UL_BIT]                  = unlocked_q;
  end
endmodule

// File: rtl/ack_wdog_checker.sv
module ack_wdog_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] deadline,
  input logic             unlocked,
  input logic             acked,
  input logic             alarm_timeout,
  input logic             alarm_key
);
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_ack_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acked |=> $stable(cnt));

  assert_locked_dl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deadline) |-> $past(unlocked));

  assert_timeout_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_timeout) |-> $past((cnt >= deadline) && (deadline != '0) && !acked));

  assert_timeout_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_timeout |=> alarm_timeout);

  assert_key_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_key |=> alarm_key);

  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (deadline == '0) |=> $stable(cnt));
endmodule

bind ack_timeout_wdog ack_wdog_checker #(.CNT_W(8)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cnt           (cnt_q),
  .deadline      (deadline_q),
  .unlocked      (unlocked_q),
  .acked         (acked_q),
  .alarm_timeout (alarm_timeout),
  .alarm_key     (alarm_key)
);

// File: tb/ack_timeout_wdog_tb.sv
module ack_timeout_wdog_tb;
  localparam int unsigned TICK = 4;
  localparam logic [31:0] KA = 32'h78A5C3E1;
  localparam logic [31:0] KB = 32'h875A3C1E;

  logic        clk, rst_n, wr_en, reg_sel;
  logic [3:0]  wr_be;
  logic [31:0] wr_data, timeout_rdata;
  logic        alarm_timeout, alarm_key;
  int          n_chk, n_fail;

  ack_timeout_wdog #(.TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_be(wr_be), .wr_data(wr_data), .timeout_rdata(timeout_rdata),
    .alarm_timeout(alarm_timeout), .alarm_key(alarm_key)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rd_dl();  return timeout_rdata[7:0];  endfunction
  function automatic logic [7:0] rd_cnt(); return timeout_rdata[15:8]; endfunction
  function automatic logic       rd_ul();  return timeout_rdata[24];   endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; reg_sel = 1'b0; wr_be = 4'h0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_be = be; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0; wr_data = '0;
  endtask

  task automatic unlock();
    wr(1'b0, 4'b1000, 32'h3200_0000);
  endtask

  task automatic t_reset();
    do_reset();
    check(timeout_rdata == 32'h0000_00FF, "R1 reset view", timeout_rdata, 32'h0000_00FF);
    check(!alarm_timeout && !alarm_key, "R1 alarms low", {alarm_timeout, alarm_key}, 0);
  endtask

  task automatic t_count();
    logic [7:0] c0, c1;
    do_reset();
    c0 = rd_cnt();
    repeat (10 * TICK) @(negedge clk);
    c1 = rd_cnt();
    check(c1 == c0 + 8'd10, "R2 ten ticks", c1, c0 + 8'd10);
    check(timeout_rdata[31:25] == 0 && timeout_rdata[23:16] == 0, "R1 unused bits zero", timeout_rdata, 0);
  endtask

  task automatic t_lock();
    do_reset();
    wr(1'b0, 4'b0001, 32'h0000_0005);
    check(rd_dl() == 8'hFF, "R5 locked write ignored", rd_dl(), 8'hFF);
    unlock();
    check(rd_ul() == 1'b1, "R4 unlocked status", rd_ul(), 1);
    wr(1'b0, 4'b0001, 32'h0000_0080);
    check(rd_dl() == 8'h80, "R4 deadline written", rd_dl(), 8'h80);
    wr(1'b0, 4'b1000, 32'h0000_0000);
    check(rd_ul() == 1'b0, "R4 relocked", rd_ul(), 0);
    wr(1'b0, 4'b0001, 32'h0000_0011);
    check(rd_dl() == 8'h80, "R5 write after relock ignored", rd_dl(), 8'h80);
    wr(1'b0, 4'b1001, 32'h3200_0022);
    check(rd_dl() == 8'h80, "R5 same-write unlock not used", rd_dl(), 8'h80);
    check(!alarm_key, "R4 no key alarm", alarm_key, 0);
  endtask

  task automatic t_badlock();
    do_reset();
    wr(1'b0, 4'b1000, 32'h4000_0000);
    check(alarm_key == 1'b1, "R7 wrong unlock alarm", alarm_key, 1);
    check(rd_ul() == 1'b0, "R7 stays locked", rd_ul(), 0);
    wr(1'b0, 4'b0001, 32'h0000_0003);
    check(rd_dl() == 8'hFF, "R7 deadline kept", rd_dl(), 8'hFF);
    repeat (10) @(negedge clk);
    check(alarm_key == 1'b1, "R7 sticky", alarm_key, 1);
  endtask

  task automatic t_timeout();
    bit seen;
    seen = 1'b0;
    do_reset();
    unlock();
    wr(1'b0, 4'b0001, 32'h0000_0003);
    check(!alarm_timeout && rd_cnt() < 8'd3, "R6 not early", rd_cnt(), 3);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (alarm_timeout) begin seen = 1'b1; break; end
    end
    check(seen, "R6 timeout raised", seen, 1);
    check(rd_cnt() == 8'd3, "R6 count at deadline", rd_cnt(), 3);
    repeat (20) @(negedge clk);
    check(alarm_timeout && rd_cnt() == 8'd3, "R6 sticky and halted", {alarm_timeout, rd_cnt()}, 32'h103);
    check(!alarm_key, "R6 no key alarm", alarm_key, 0);
  endtask

  task automatic t_ack();
    logic [7:0] c0, c1;
    do_reset();
    repeat (20) @(negedge clk);
    check(rd_cnt() > 0, "R2 counting before ack", rd_cnt(), 1);
    wr(1'b1, 4'hF, KA);
    wr(1'b1, 4'hF, KB);
    c0 = rd_cnt();
    repeat (40) @(negedge clk);
    c1 = rd_cnt();
    check(c1 == c0, "R3 counter frozen", c1, c0);
    wr(1'b1, 4'hF, 32'hDEAD_BEEF);
    check(!alarm_key, "R3 later ack write ignored", alarm_key, 0);
    unlock();
    wr(1'b0, 4'b0001, 32'h0000_0001);
    repeat (3) @(negedge clk);
    check(!alarm_timeout, "R3 no timeout after ack", alarm_timeout, 0);
  endtask

  task automatic t_badack();
    logic [7:0] c0, c1;
    do_reset();
    wr(1'b1, 4'hF, KA);
    check(!alarm_key, "R8 first key accepted", alarm_key, 0);
    wr(1'b1, 4'hF, 32'h1234_5678);
    check(alarm_key, "R8 wrong second key", alarm_key, 1);
    c0 = rd_cnt();
    repeat (8 * TICK) @(negedge clk);
    c1 = rd_cnt();
    check(c1 == c0 + 8'd8, "R8 counter keeps running", c1, c0 + 8'd8);
    wr(1'b1, 4'hF, KA);
    wr(1'b1, 4'hF, KB);
    c0 = rd_cnt();
    repeat (20) @(negedge clk);
    check(rd_cnt() == c0, "R8 sequence restarted", rd_cnt(), c0);
    do_reset();
    wr(1'b1, 4'hF, KB);
    check(alarm_key, "R8 second key first", alarm_key, 1);
    do_reset();
    wr(1'b1, 4'b0111, KA);
    check(alarm_key, "R8 partial lanes", alarm_key, 1);
  endtask

  task automatic t_disable();
    logic [7:0] c0;
    do_reset();
    unlock();
    wr(1'b0, 4'b0001, 32'h0000_0000);
    c0 = rd_cnt();
    repeat (300 * TICK / 4) @(negedge clk);
    check(rd_cnt() == c0, "R9 counter held", rd_cnt(), c0);
    check(!alarm_timeout, "R9 no timeout", alarm_timeout, 0);
  endtask

  task automatic t_lower();
    logic [7:0] c0;
    do_reset();
    repeat (15 * TICK) @(negedge clk);
    check(rd_cnt() >= 8'd10, "R10 count advanced", rd_cnt(), 10);
    unlock();
    wr(1'b0, 4'b0001, 32'h0000_0005);
    c0 = rd_cnt();
    @(negedge clk);
    check(alarm_timeout, "R10 immediate timeout", alarm_timeout, 1);
    repeat (10) @(negedge clk);
    check(rd_cnt() == c0, "R10 count frozen", rd_cnt(), c0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; reg_sel = 1'b0; wr_be = 4'h0; wr_data = '0;
    t_reset();
    t_count();
    t_lock();
    t_badlock();
    t_timeout();
    t_ack();
    t_badack();
    t_disable();
    t_lower();
    finish_run();
  end
endmodule